// File: doc/BRIEF.md
# Right-to-left modular exponentiation unit

This block raises a base X to a power E modulo an odd modulus N and returns Y = X^E mod N. It walks the exponent from its least significant bit upward. Two running values are kept: an accumulated result and a repeatedly squared base. Two identical sequential Montgomery product cores do the arithmetic. In each exponent step, one core squares the base. The other core multiplies the result by the base, but only when the current exponent bit is 1. Both cores start in the same cycle, and the step finishes once every core that was launched has finished.

The caller supplies X, E, N and the constant 2^(2W) mod N, where W is the operand width, and then pulses a start strobe. The block moves both running values into the Montgomery domain itself. It multiplies the constant by 1 to get the domain form of 1, and multiplies X by the constant to get the domain form of the base. At the end it multiplies the result by 1 to bring it back to an ordinary integer. A one-cycle done pulse marks a new result. The operand width and the exponent width are parameters and default to 8 bits each.

Top module: `modexp_rl`

## Requirements
- R1: After reset, done_o is 0 and y_o is 0.
- R2: For every odd N in 3..2^W-1, every X below 2^W and every E below 2^EW, the result is X^E mod N. The exponent is consumed from bit 0 up to bit EW-1, with one square per bit and one multiply for each bit that is 1.
- R3: An exponent of 0 gives a result of 1, whatever X is.
- R4: With N=55 and W=8, X=2 and E=3 give 8, and X=8 and E=27 give 2.
- R5: done_o is high for exactly one cycle per result. y_o changes only in the cycle where done_o is high, and it holds its value until the next result.
- R6: A start pulse that arrives while a computation is running is ignored. Only one result is produced, and it is the result for the operands captured at the accepted start.
- R7: X, E, N and the constant are captured in the cycle where start is accepted. Changing these inputs later, during the run, has no effect on the result.
- R8: A base X that is equal to or above N is reduced correctly, giving the same result as X mod N.
- R9: Every result on y_o is strictly below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when the unit is idle |
| x_i | input | W | Base |
| e_i | input | EW | Exponent |
| n_i | input | W | Odd modulus, at least 3 |
| r2_i | input | W | The constant 2^(2W) mod N |
| done_o | output | 1 | One-cycle pulse when a new result is on y_o |
| y_o | output | W | Result X^E mod N |

## Verification
The hardest situation to reach from the ports is a step where the square core runs alone. In such a step, any stale completion flag from the multiply core must not let the step finish early, and must not overwrite the result. Exponents with scattered, single or zero bits bring this about: 0, 128, 3, 27 and random values, placed between runs that use all-ones exponents. A second start pulse and input changes in the middle of a run exercise the capture of operands at start. A long quiet window after the run then checks that no extra result appears.

// File: rtl/modexp_pkg.sv
`timescale 1ns/1ps
package modexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IN_GO,
    ST_IN_WT,
    ST_LP_CHK,
    ST_LP_WT,
    ST_OUT_GO,
    ST_OUT_WT
  } mx_state_e;

endpackage

// File: rtl/modexp_mont_core.sv
`timescale 1ns/1ps
module modexp_mont_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] n_i,
  output logic         done_o,
  output logic [W-1:0] p_o
);
  localparam int CW = $clog2(W + 1);
  localparam int SW = W + 1;

  // One radix-2 step: add b when the multiplier bit is set, make even with n, halve.
  function automatic logic [SW-1:0] mont_step(logic [SW-1:0] s, logic xb,
                                              logic [W-1:0] b, logic [W-1:0] n);
    logic [W+1:0] t;
    t = {1'b0, s} + (xb ? {2'b00, b} : '0);
    if (t[0]) t = t + {2'b00, n};
    return t[W+1:1];
  endfunction

  // Partial sum is below 2n; one conditional subtraction brings it below n.
  function automatic logic [W-1:0] final_sub(logic [SW-1:0] s, logic [W-1:0] n);
    logic [SW-1:0] d;
    d = s - {1'b0, n};
    return (s >= {1'b0, n}) ? d[W-1:0] : s[W-1:0];
  endfunction

  logic [W-1:0]  a_q, b_q, n_q, p_q;
  logic [SW-1:0] s_q;
  logic [CW-1:0] k_q;
  logic          run_q, fin_q, done_q;
  logic          accept, step_last;

  assign accept    = go_i && !run_q && !fin_q;
  assign step_last = run_q && (k_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      p_q    <= '0;
      s_q    <= '0;
      k_q    <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_q   <= a_i;
        b_q   <= b_i;
        n_q   <= n_i;
        s_q   <= '0;
        k_q   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        s_q <= mont_step(s_q, a_q[0], b_q, n_q);
        a_q <= a_q >> 1;
        k_q <= k_q + CW'(1);
        if (step_last) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end else if (fin_q) begin
        p_q    <= final_sub(s_q, n_q);
        done_q <= 1'b1;
        fin_q  <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign p_o    = p_q;

  // R9: the running partial sum stays below twice the modulus
  p_core_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (s_q < {n_q, 1'b0}));

  // R9: a delivered product is fully reduced
  p_core_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (p_o < n_q));

  // R5: core completion is a single-cycle event
  p_core_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/modexp_exp_scan.sv
`timescale 1ns/1ps
module modexp_exp_scan #(
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [EW-1:0] e_i,
  input  logic          step_i,
  output logic          bit_o,
  output logic          end_o
);
  localparam int NW = $clog2(EW + 1);

  logic [EW-1:0] e_q;
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      e_q   <= e_i;
      cnt_q <= '0;
    end else if (step_i) begin
      e_q   <= e_q >> 1;
      cnt_q <= cnt_q + NW'(1);
    end
  end

  assign bit_o = e_q[0];
  assign end_o = (cnt_q == NW'(EW));

  // R2: no step is taken past the last exponent bit
  p_scan_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !end_o);

  // R2: the step count never exceeds the exponent width
  p_scan_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NW'(EW));

endmodule

// File: rtl/modexp_rl.sv
`timescale 1ns/1ps
module modexp_rl #(
  parameter int W  = 8,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  x_i,
  input  logic [EW-1:0] e_i,
  input  logic [W-1:0]  n_i,
  input  logic [W-1:0]  r2_i,
  output logic          done_o,
  output logic [W-1:0]  y_o
);
  import modexp_pkg::*;

  mx_state_e    st_q;
  logic [W-1:0] n_q, r2_q, x_q, ym_q, sm_q, y_q;
  logic         done_q, mul_en_q;
  logic         mul_seen_q, sqr_seen_q;

  // named internal events
  logic         mul_go, sqr_go, mul_done, sqr_done, mul_fin, sqr_fin;
  logic [W-1:0] mul_a, mul_b, sqr_a, sqr_b, mul_p, sqr_p;
  logic         e_bit, e_end, e_load, e_step, lp_ready;

  assign mul_fin  = mul_seen_q | mul_done;
  assign sqr_fin  = sqr_seen_q | sqr_done;
  assign lp_ready = sqr_fin && (mul_fin || !mul_en_q);
  assign e_load   = (st_q == ST_IDLE) && start_i;
  assign e_step   = (st_q == ST_LP_WT) && lp_ready;

  // operand routing to the two product cores
  always_comb begin
    mul_go = 1'b0;
    sqr_go = 1'b0;
    mul_a  = '0;
    mul_b  = '0;
    sqr_a  = '0;
    sqr_b  = '0;
    unique case (st_q)
      ST_IN_GO: begin
        mul_go = 1'b1;
        mul_a  = r2_q;
        mul_b  = W'(1);
        sqr_go = 1'b1;
        sqr_a  = x_q;
        sqr_b  = r2_q;
      end
      ST_LP_CHK: begin
        if (!e_end) begin
          sqr_go = 1'b1;
          sqr_a  = sm_q;
          sqr_b  = sm_q;
          mul_go = e_bit;
          mul_a  = ym_q;
          mul_b  = sm_q;
        end
      end
      ST_OUT_GO: begin
        mul_go = 1'b1;
        mul_a  = ym_q;
        mul_b  = W'(1);
      end
      default: ;
    endcase
  end

  modexp_mont_core #(.W(W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (mul_go),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .n_i    (n_q),
    .done_o (mul_done),
    .p_o    (mul_p)
  );

  modexp_mont_core #(.W(W)) u_sqr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (sqr_go),
    .a_i    (sqr_a),
    .b_i    (sqr_b),
    .n_i    (n_q),
    .done_o (sqr_done),
    .p_o    (sqr_p)
  );

  modexp_exp_scan #(.EW(EW)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (e_load),
    .e_i    (e_i),
    .step_i (e_step),
    .bit_o  (e_bit),
    .end_o  (e_end)
  );

  // sticky completion flags, cleared by each launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_seen_q <= 1'b0;
      sqr_seen_q <= 1'b0;
    end else begin
      if (mul_go)        mul_seen_q <= 1'b0;
      else if (mul_done) mul_seen_q <= 1'b1;
      if (sqr_go)        sqr_seen_q <= 1'b0;
      else if (sqr_done) sqr_seen_q <= 1'b1;
    end
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      n_q      <= '0;
      r2_q     <= '0;
      x_q      <= '0;
      ym_q     <= '0;
      sm_q     <= '0;
      y_q      <= '0;
      done_q   <= 1'b0;
      mul_en_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            n_q  <= n_i;
            r2_q <= r2_i;
            x_q  <= x_i;
            st_q <= ST_IN_GO;
          end
        end
        ST_IN_GO: begin
          mul_en_q <= 1'b1;
          st_q     <= ST_IN_WT;
        end
        ST_IN_WT: begin
          if (mul_fin && sqr_fin) begin
            ym_q <= mul_p;
            sm_q <= sqr_p;
            st_q <= ST_LP_CHK;
          end
        end
        ST_LP_CHK: begin
          if (e_end) begin
            st_q <= ST_OUT_GO;
          end else begin
            mul_en_q <= e_bit;
            st_q     <= ST_LP_WT;
          end
        end
        ST_LP_WT: begin
          if (lp_ready) begin
            sm_q <= sqr_p;
            if (mul_en_q) ym_q <= mul_p;
            st_q <= ST_LP_CHK;
          end
        end
        ST_OUT_GO: begin
          st_q <= ST_OUT_WT;
        end
        ST_OUT_WT: begin
          if (mul_fin) begin
            y_q    <= mul_p;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign y_o    = y_q;

  // R5: result strobe lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: the result only moves together with the strobe
  p_y_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(y_o));

  // R9: delivered result is below the captured modulus
  p_y_below_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (y_o < n_q));

  // R9: both running values stay reduced between steps
  p_running_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LP_CHK) |-> ((ym_q < n_q) && (sm_q < n_q)));

  // R2: a multiply core left idle in a step reports no completion
  p_mul_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LP_WT && !mul_en_q) |-> !mul_done);

  // R2: cores launched together finish together
  p_pair_lockstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LP_WT && mul_en_q) |-> (mul_done == sqr_done));

  // R6: a start during a run leaves the captured modulus alone
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_i) |=> $stable(n_q));

endmodule

// File: tb/modexp_rl_bench.sv
`timescale 1ns/1ps
module modexp_rl_bench;
  localparam int W  = 8;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  x_i = '0, n_i = '0, r2_i = '0;
  logic [EW-1:0] e_i = '0;
  logic          done_o;
  logic [W-1:0]  y_o;

  always #2.5 clk = ~clk;

  modexp_rl #(.W(W), .EW(EW)) u_modexp_rl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .e_i(e_i),
    .n_i(n_i), .r2_i(r2_i), .done_o(done_o), .y_o(y_o)
  );

  int total = 0, bad = 0, got = 0, cyc = 0;
  int exp_q[$];
  int nmod_q[$];
  string tag_q[$];
  int ev, nv;
  string tv;
  logic prev_done = 1'b0;
  logic [W-1:0] prev_y = '0;
  bit finished = 1'b0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // left-to-right evaluation, independent of the design's scan order
  function automatic int ref_pow(int x, int e, int n);
    longint acc, b;
    acc = 1 % n;
    b = x % n;
    for (int i = EW - 1; i >= 0; i--) begin
      acc = (acc * acc) % n;
      if (((e >> i) & 1) != 0) acc = (acc * b) % n;
    end
    return int'(acc);
  endfunction

  function automatic int ref_r2(int n);
    longint v = 1;
    for (int i = 0; i < 2 * W; i++) v = (v * 2) % n;
    return int'(v);
  endfunction

  task automatic launch(int x, int e, int n);
    @(negedge clk);
    x_i = W'(x); e_i = EW'(e); n_i = W'(n); r2_i = W'(ref_r2(n));
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push_exp(int x, int e, int n, string tag);
    exp_q.push_back(ref_pow(x, e, n));
    nmod_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  task automatic run_op(int x, int e, int n, string tag);
    int g0;
    push_exp(x, e, n, tag);
    g0 = got;
    launch(x, e, n);
    while (got == g0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check("R5 done pulse width", int'(done_o), 0);
      if (!done_o && y_o !== prev_y) check("R5 Y held between results", int'(y_o), int'(prev_y));
      if (done_o) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R6 unexpected result actual=%0d expected=none", y_o);
        end else begin
          ev = exp_q.pop_front();
          nv = nmod_q.pop_front();
          tv = tag_q.pop_front();
          check(tv, int'(y_o), ev);
          check("R9 result below N", int'(y_o < W'(nv)), 1);
        end
        got++;
      end
    end
    prev_done = done_o;
    prev_y    = y_o;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=completion", cyc);
      finish_run();
    end
  end

  initial begin
    int g0;
    int unsigned seed;
    int rx, re, rn;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset y", int'(y_o), 0);

    run_op(2, 3, 55, "R4 small encrypt");
    run_op(8, 27, 55, "R4 small decrypt");
    run_op(123, 0, 55, "R3 zero exponent");
    run_op(200, 0, 201, "R3 zero exponent large N");
    run_op(250, 5, 13, "R8 base above N");
    run_op(55, 3, 55, "R8 base equal N");
    run_op(0, 7, 97, "R2 zero base");
    run_op(77, 255, 253, "R2 all-ones exponent");
    run_op(3, 128, 251, "R2 top bit only");
    run_op(6, 1, 3, "R2 smallest modulus");

    // R6: second start mid-run is ignored
    push_exp(9, 100, 211, "R6 first operands win");
    g0 = got;
    launch(9, 100, 211);
    repeat (20) @(negedge clk);
    launch(17, 3, 101);
    while (got == g0) @(negedge clk);
    repeat (400) @(negedge clk);
    check("R6 single result", got - g0, 1);

    // R7: inputs changed after capture
    push_exp(45, 77, 239, "R7 captured operands");
    g0 = got;
    launch(45, 77, 239);
    repeat (10) @(negedge clk);
    x_i = 8'd3; e_i = 8'd1; n_i = 8'd7; r2_i = 8'd2;
    while (got == g0) @(negedge clk);
    repeat (3) @(negedge clk);

    seed = 32'h1234_5678;
    for (int k = 0; k < 25; k++) begin
      seed = seed * 1103515245 + 12345;
      rx = int'(seed[23:16]);
      re = int'(seed[15:8]);
      seed = seed * 1103515245 + 12345;
      rn = int'((seed[23:8] % 126) * 2 + 3);
      run_op(rx, re, rn, "R2 random operands");
    end

    check("R2 queue drained", exp_q.size(), 0);
    finished = 1'b1;
    finish_run();
  end

endmodule